// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block sorts every memory access by its 32-bit virtual address and the privilege of the requester. It names the address area the access falls in and says whether the access may use the cache, whether it must be looked up in the translation buffer, whether it is illegal, and which write policy applies. When an area is not translated, the block forms the physical address itself. When an area is translated and the MMU is on, the block forwards the physical address and page attributes of the translation-buffer hit that come with the request. It also checks those attributes for an unsupported page size and for a cacheable mapping onto the control-register region.

Privileged code sees five fixed segments with fixed cache and translation rules. User code sees one translatable low half. Above it lies a faulting band, and the top band is also faulting except for a store-queue window and an on-chip memory window. The write policy comes from a global control bit when translation is off and from the page when it is on.

Each result passes through one output register with a valid/ready handshake. A new request is taken whenever that register is empty or is being drained in the same cycle.

Top module: `va_region_decoder`

## Requirements
- R1: In privileged mode (`priv`=1) the area code is P0=2 for 0x00000000–0x7FFFFFFF, P1=3 for 0x80000000–0x9FFFFFFF, P2=4 for 0xA0000000–0xBFFFFFFF, P3=5 for 0xC0000000–0xDFFFFFFF and P4=6 for 0xE0000000–0xFFFFFFFF. None of these raises an address error.
- R2: In user mode (`priv`=0) 0x00000000–0x7FFFFFFF is area U0=1, and 0x80000000–0xDFFFFFFF raises an address error.
- R3: In user mode, 0xE0000000–0xE3FFFFFF is the store-queue window (area 7) and 0xE5000000–0xE5FFFFFF is the on-chip memory window (area 8). Every other address from 0xE4000000 upward raises an address error.
- R4: For U0, P0 and P3 with `mmu_en`=0, the outputs are need_xlat=0, pa = va with bits 31:29 cleared, cacheable=`cache_en` and wt=`glob_wt`.
- R5: For U0, P0 and P3 with `mmu_en`=1, the outputs are need_xlat=1, pa=`pg_pa`, cacheable=`cache_en`&`pg_c` and wt=`pg_wt`.
- R6: P1 and P2 are never translated and take pa = va with bits 31:29 cleared. P1 gives cacheable=`cache_en` and wt=`glob_wt`. P2 gives cacheable=0 and wt=0.
- R7: P4, the store-queue window and the on-chip memory window are never translated and take pa = va, cacheable=0 and wt=0.
- R8: When need_xlat=1, size_bad is raised for a `pg_size` code outside the allowed set. Codes are 0=1K, 1=4K, 2=8K, 3=64K, 4=256K, 5=1M, 6=4M, 7=64M. With `tlb_ext`=0 only codes 0, 1, 3 and 5 are allowed. With `tlb_ext`=1 codes 0–7 are allowed. Codes 8–15 are never allowed. When need_xlat=0, size_bad is 0.
- R9: cfg_viol is 1 exactly when need_xlat=1, `pg_pa`[31:29]=3'b111 and `pg_c`=1.
- R10: On an address error, area is 0 and cacheable, need_xlat, wt, pa, size_bad and cfg_viol are all 0.
- R11: A request is accepted when in_valid=1 and (out_valid=0 or out_ready=1), and its result appears on the outputs with out_valid=1 at the next clock edge. While out_valid=1 and out_ready=0, all outputs hold their values.
- R12: While `rst` is high, and on the first edge after it falls, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| va | input | 32 | Virtual address |
| priv | input | 1 | 1 = privileged, 0 = user |
| mmu_en | input | 1 | Address translation enabled |
| tlb_ext | input | 1 | 1 = extended page-size set |
| cache_en | input | 1 | Global cache enable |
| glob_wt | input | 1 | Global write-through select |
| pg_pa | input | 32 | Physical address from the translation hit |
| pg_c | input | 1 | Page cacheable bit |
| pg_wt | input | 1 | Page write-through bit |
| pg_size | input | 4 | Page-size code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes result |
| out_area | output | 4 | Area code |
| out_cacheable | output | 1 | Access may use the cache |
| out_need_xlat | output | 1 | Access uses translation |
| out_addr_err | output | 1 | Address error |
| out_wt | output | 1 | Write-through select |
| out_pa | output | 32 | Physical address |
| out_size_bad | output | 1 | Unsupported page size |
| out_cfg_viol | output | 1 | Cacheable mapping onto control-register region |

## Verification
The case that is hardest to reach from the ports is a new request arriving while the output register is full and stalled, together with a fault attribute such as a cacheable page aimed at physical region 7 in compatible mode. The bench first walks every region boundary under both privilege levels with translation on and off. It then runs a long random phase. In that phase `out_ready` is low about a third of the time, addresses are drawn near the window edges, and the top bits of `pg_pa` are forced to 3'b111 often. This lets stalls, size violations and control-region violations coincide in the same cycles.

// File: rtl/va_region_pkg.sv
package va_region_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int PSZ_W  = 4;
    localparam int AREA_W = 4;
    localparam int SEG_W  = 3;
    localparam int SEG_LSB = VA_W - SEG_W;

    // upper bits that identify the user windows inside the top segment
    localparam int SQ_TAG_W  = 6;
    localparam logic [SQ_TAG_W-1:0] SQ_TAG = 6'b111000;
    localparam int OCM_TAG_W = 8;
    localparam logic [OCM_TAG_W-1:0] OCM_TAG = 8'hE5;

    localparam logic [SEG_W-1:0] CTRL_SEG = 3'b111;

    typedef enum logic [AREA_W-1:0] {
        AREA_NONE = 4'd0,
        AREA_U0   = 4'd1,
        AREA_P0   = 4'd2,
        AREA_P1   = 4'd3,
        AREA_P2   = 4'd4,
        AREA_P3   = 4'd5,
        AREA_P4   = 4'd6,
        AREA_SQ   = 4'd7,
        AREA_OCM  = 4'd8
    } area_e;

    typedef struct packed {
        area_e area;
        logic  fault;
        logic  xlat_able;
    } seg_info_t;

    typedef struct packed {
        area_e            area;
        logic             cacheable;
        logic             need_xlat;
        logic             addr_err;
        logic             wt;
        logic [PA_W-1:0]  pa;
        logic             size_bad;
        logic             cfg_viol;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    function automatic logic size_code_ok(input logic [PSZ_W-1:0] code,
                                          input logic ext);
        logic ok;
        if (ext) begin
            ok = (code < 4'd8);
        end else begin
            unique case (code)
                4'd0, 4'd1, 4'd3, 4'd5: ok = 1'b1;
                default:                ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    function automatic logic [PA_W-1:0] strip_seg(input logic [VA_W-1:0] a);
        return {{SEG_W{1'b0}}, a[SEG_LSB-1:0]};
    endfunction

endpackage

// File: rtl/va_area_classify.sv
module va_area_classify
    import va_region_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            priv,
    output seg_info_t       seg
);
    logic [SEG_W-1:0] top;
    logic in_sq, in_ocm;

    assign top    = va[VA_W-1:SEG_LSB];
    assign in_sq  = (va[VA_W-1 -: SQ_TAG_W]  == SQ_TAG);
    assign in_ocm = (va[VA_W-1 -: OCM_TAG_W] == OCM_TAG);

    always_comb begin
        seg = '{area: AREA_NONE, fault: 1'b0, xlat_able: 1'b0};
        if (priv) begin
            unique case (top)
                3'd4:    seg.area = AREA_P1;
                3'd5:    seg.area = AREA_P2;
                3'd6:    begin seg.area = AREA_P3; seg.xlat_able = 1'b1; end
                3'd7:    seg.area = AREA_P4;
                default: begin seg.area = AREA_P0; seg.xlat_able = 1'b1; end
            endcase
        end else if (!va[VA_W-1]) begin
            seg.area      = AREA_U0;
            seg.xlat_able = 1'b1;
        end else if (top == 3'd7 && in_sq) begin
            seg.area = AREA_SQ;
        end else if (top == 3'd7 && in_ocm) begin
            seg.area = AREA_OCM;
        end else begin
            seg.fault = 1'b1;
        end
    end
endmodule

// File: rtl/va_page_check.sv
module va_page_check
    import va_region_pkg::*;
(
    input  logic             active,
    input  logic             tlb_ext,
    input  logic [PSZ_W-1:0] pg_size,
    input  logic [PA_W-1:0]  pg_pa,
    input  logic             pg_c,
    output logic             size_bad,
    output logic             cfg_viol
);
    always_comb begin
        size_bad = active && !size_code_ok(pg_size, tlb_ext);
        cfg_viol = active && pg_c && (pg_pa[PA_W-1 -: SEG_W] == CTRL_SEG);
    end
endmodule

// File: rtl/va_attr_resolve.sv
module va_attr_resolve
    import va_region_pkg::*;
(
    input  seg_info_t        seg,
    input  logic [VA_W-1:0]  va,
    input  logic             mmu_en,
    input  logic             cache_en,
    input  logic             glob_wt,
    input  logic [PA_W-1:0]  pg_pa,
    input  logic             pg_c,
    input  logic             pg_wt,
    input  logic             size_bad,
    input  logic             cfg_viol,
    output logic             xlat_on,
    output attr_t            attr
);
    assign xlat_on = !seg.fault && seg.xlat_able && mmu_en;

    always_comb begin
        attr = '0;
        if (!seg.fault) begin
            attr.area = seg.area;
            if (seg.xlat_able) begin
                if (mmu_en) begin
                    attr.need_xlat = 1'b1;
                    attr.pa        = pg_pa;
                    attr.cacheable = cache_en & pg_c;
                    attr.wt        = pg_wt;
                    attr.size_bad  = size_bad;
                    attr.cfg_viol  = cfg_viol;
                end else begin
                    attr.pa        = strip_seg(va);
                    attr.cacheable = cache_en;
                    attr.wt        = glob_wt;
                end
            end else begin
                unique case (seg.area)
                    AREA_P1: begin
                        attr.pa        = strip_seg(va);
                        attr.cacheable = cache_en;
                        attr.wt        = glob_wt;
                    end
                    AREA_P2: attr.pa = strip_seg(va);
                    default: attr.pa = va;
                endcase
            end
        end else begin
            attr.addr_err = 1'b1;
        end
    end
endmodule

// File: rtl/va_out_stage.sv
module va_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/va_region_decoder.sv
module va_region_decoder
    import va_region_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VA_W-1:0]   va,
    input  logic              priv,
    input  logic              mmu_en,
    input  logic              tlb_ext,
    input  logic              cache_en,
    input  logic              glob_wt,
    input  logic [PA_W-1:0]   pg_pa,
    input  logic              pg_c,
    input  logic              pg_wt,
    input  logic [PSZ_W-1:0]  pg_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [AREA_W-1:0] out_area,
    output logic              out_cacheable,
    output logic              out_need_xlat,
    output logic              out_addr_err,
    output logic              out_wt,
    output logic [PA_W-1:0]   out_pa,
    output logic              out_size_bad,
    output logic              out_cfg_viol
);
    seg_info_t seg;
    attr_t     attr_d;
    attr_t     attr_q;
    logic      xlat_on;
    logic      size_bad, cfg_viol;
    logic [ATTR_W-1:0] q_bits;

    va_area_classify u_cls (
        .va   (va),
        .priv (priv),
        .seg  (seg)
    );

    va_page_check u_pchk (
        .active   (xlat_on),
        .tlb_ext  (tlb_ext),
        .pg_size  (pg_size),
        .pg_pa    (pg_pa),
        .pg_c     (pg_c),
        .size_bad (size_bad),
        .cfg_viol (cfg_viol)
    );

    va_attr_resolve u_res (
        .seg      (seg),
        .va       (va),
        .mmu_en   (mmu_en),
        .cache_en (cache_en),
        .glob_wt  (glob_wt),
        .pg_pa    (pg_pa),
        .pg_c     (pg_c),
        .pg_wt    (pg_wt),
        .size_bad (size_bad),
        .cfg_viol (cfg_viol),
        .xlat_on  (xlat_on),
        .attr     (attr_d)
    );

    va_out_stage #(.DW(ATTR_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (attr_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (q_bits)
    );

    assign attr_q        = attr_t'(q_bits);
    assign out_area      = attr_q.area;
    assign out_cacheable = attr_q.cacheable;
    assign out_need_xlat = attr_q.need_xlat;
    assign out_addr_err  = attr_q.addr_err;
    assign out_wt        = attr_q.wt;
    assign out_pa        = attr_q.pa;
    assign out_size_bad  = attr_q.size_bad;
    assign out_cfg_viol  = attr_q.cfg_viol;
endmodule

// File: rtl/va_region_decoder_chk.sv
module va_region_decoder_chk
    import va_region_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [AREA_W-1:0] out_area,
    input logic              out_cacheable,
    input logic              out_need_xlat,
    input logic              out_addr_err,
    input logic              out_wt,
    input logic [PA_W-1:0]   out_pa,
    input logic              out_size_bad,
    input logic              out_cfg_viol
);
    logic xl_area, strip_area, raw_area;
    assign xl_area    = (out_area == AREA_U0) || (out_area == AREA_P0) || (out_area == AREA_P3);
    assign strip_area = xl_area || (out_area == AREA_P1) || (out_area == AREA_P2);
    assign raw_area   = (out_area == AREA_P4) || (out_area == AREA_SQ) || (out_area == AREA_OCM);

    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_addr_err |-> out_area == '0 && !out_cacheable && !out_need_xlat
            && !out_wt && out_pa == '0 && !out_size_bad && !out_cfg_viol);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_area) && $stable(out_pa)
            && $stable(out_cacheable) && $stable(out_wt) && $stable(out_addr_err)
            && $stable(out_need_xlat) && $stable(out_size_bad) && $stable(out_cfg_viol));

    // R9
    cfg_region_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cfg_viol |-> out_need_xlat && out_pa[PA_W-1 -: SEG_W] == CTRL_SEG);

    // R5
    xlat_area_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_need_xlat |-> xl_area);

    // R8
    size_scope_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_size_bad |-> out_need_xlat);

    // R4
    strip_pa_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_need_xlat && strip_area |-> out_pa[PA_W-1 -: SEG_W] == '0);

    // R7
    raw_nocache_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && raw_area |-> !out_cacheable && !out_wt && !out_need_xlat);

    // R12
    reset_empty_chk: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

bind va_region_decoder va_region_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_area      (out_area),
    .out_cacheable (out_cacheable),
    .out_need_xlat (out_need_xlat),
    .out_addr_err  (out_addr_err),
    .out_wt        (out_wt),
    .out_pa        (out_pa),
    .out_size_bad  (out_size_bad),
    .out_cfg_viol  (out_cfg_viol)
);

// File: tb/va_region_decoder_tb.sv
`timescale 1ns/1ps
module va_region_decoder_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        in_valid = 0, in_ready;
    logic [31:0] va = 0;
    logic        priv = 0, mmu_en = 0, tlb_ext = 0, cache_en = 0, glob_wt = 0;
    logic [31:0] pg_pa = 0;
    logic        pg_c = 0, pg_wt = 0;
    logic [3:0]  pg_size = 0;
    logic        out_valid, out_ready = 0;
    logic [3:0]  out_area;
    logic        out_cacheable, out_need_xlat, out_addr_err, out_wt;
    logic [31:0] out_pa;
    logic        out_size_bad, out_cfg_viol;

    va_region_decoder u_dut (.*);

    typedef struct {
        int          area;
        bit          err, cach, xl, wt, sb, cv;
        logic [31:0] pa;
    } exp_t;

    int   total = 0, bad = 0;
    bit   done = 0;
    bit   exp_v = 0;
    bit   in_rst_phase = 1;
    exp_t exp_q;

    function automatic exp_t refm();
        exp_t e;
        bit   tr;
        e = '{area: 0, err: 0, cach: 0, xl: 0, wt: 0, sb: 0, cv: 0, pa: 32'h0};
        tr = 0;
        if (priv) begin
            if (va < 32'h8000_0000)      begin e.area = 2; tr = 1; end
            else if (va < 32'hA000_0000) e.area = 3;
            else if (va < 32'hC000_0000) e.area = 4;
            else if (va < 32'hE000_0000) begin e.area = 5; tr = 1; end
            else                         e.area = 6;
        end else begin
            if (va < 32'h8000_0000)      begin e.area = 1; tr = 1; end
            else if (va < 32'hE000_0000) e.err = 1;
            else if (va < 32'hE400_0000) e.area = 7;
            else if (va >= 32'hE500_0000 && va < 32'hE600_0000) e.area = 8;
            else                         e.err = 1;
        end
        if (e.err) return e;
        if (tr && mmu_en) begin
            e.xl   = 1;
            e.pa   = pg_pa;
            e.cach = cache_en && pg_c;
            e.wt   = pg_wt;
            e.sb   = tlb_ext ? (pg_size > 7)
                             : !(pg_size == 0 || pg_size == 1 || pg_size == 3 || pg_size == 5);
            e.cv   = pg_c && (pg_pa >= 32'hE000_0000);
        end else if (tr || e.area == 3) begin
            e.pa   = va % 32'h2000_0000;
            e.cach = cache_en;
            e.wt   = glob_wt;
        end else if (e.area == 4) begin
            e.pa = va % 32'h2000_0000;
        end else begin
            e.pa = va;
        end
        return e;
    endfunction

    // behavioural model of the registered stage
    always @(posedge clk) begin
        if (rst) begin
            exp_v = 0;
        end else if (!exp_v || out_ready) begin
            exp_v = in_valid;
            if (in_valid) exp_q = refm();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic string area_tag(exp_t e);
        if (e.area >= 2 && e.area <= 6) return "R1";
        if (e.area == 7 || e.area == 8) return "R3";
        if (e.err && !priv_was_user_top(e)) return "R2";
        return "R3";
    endfunction

    logic [31:0] va_q;
    always @(posedge clk) if (!rst && (!exp_v || out_ready) && in_valid) va_q <= va;

    function automatic bit priv_was_user_top(exp_t e);
        return e.err && (va_q >= 32'hE000_0000);
    endfunction

    function automatic string attr_tag(exp_t e);
        if (e.err) return "R10";
        if (e.area == 1 || e.area == 2 || e.area == 5) return e.xl ? "R5" : "R4";
        if (e.area == 3 || e.area == 4) return "R6";
        return "R7";
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            if (exp_v) begin
                chk(out_valid == 1'b1, "R11", "out_valid", 32'(out_valid), 32'd1);
                chk(out_area == 4'(exp_q.area), area_tag(exp_q), "area", 32'(out_area), 32'(exp_q.area));
                chk(out_addr_err == exp_q.err, exp_q.err ? "R10" : area_tag(exp_q), "addr_err",
                    32'(out_addr_err), 32'(exp_q.err));
                chk(out_pa == exp_q.pa, attr_tag(exp_q), "pa", out_pa, exp_q.pa);
                chk(out_cacheable == exp_q.cach, attr_tag(exp_q), "cacheable",
                    32'(out_cacheable), 32'(exp_q.cach));
                chk(out_wt == exp_q.wt, attr_tag(exp_q), "wt", 32'(out_wt), 32'(exp_q.wt));
                chk(out_need_xlat == exp_q.xl, attr_tag(exp_q), "need_xlat",
                    32'(out_need_xlat), 32'(exp_q.xl));
                chk(out_size_bad == exp_q.sb, "R8", "size_bad", 32'(out_size_bad), 32'(exp_q.sb));
                chk(out_cfg_viol == exp_q.cv, "R9", "cfg_viol", 32'(out_cfg_viol), 32'(exp_q.cv));
            end else begin
                chk(out_valid == 1'b0, in_rst_phase ? "R12" : "R11", "out_valid",
                    32'(out_valid), 32'd0);
            end
        end
    end

    localparam int NB = 16;
    logic [31:0] edges [NB] = '{
        32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
        32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
        32'hE000_0000, 32'hE3FF_FFFF, 32'hE400_0000, 32'hE4FF_FFFF,
        32'hE500_0000, 32'hE5FF_FFFF, 32'hE600_0000, 32'hFFFF_FFFF
    };

    task automatic rand_page();
        pg_pa   = $urandom;
        if ($urandom_range(0, 2) == 0) pg_pa[31:29] = 3'b111;
        pg_c    = 1'($urandom);
        pg_wt   = 1'($urandom);
        pg_size = 4'($urandom);
        cache_en = 1'($urandom);
        glob_wt  = 1'($urandom);
        tlb_ext  = 1'($urandom);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL R11 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        in_rst_phase = 0;
        out_ready = 1;
        // boundary sweep: R1 R2 R3 R4 R5 R6 R7
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < NB; i++) begin
                    priv = 1'(p); mmu_en = 1'(m);
                    va = edges[i];
                    rand_page();
                    in_valid = 1;
                    @(negedge clk);
                end
            end
        end
        // random phase with stalls: R8 R9 R10 R11
        for (int n = 0; n < 6000; n++) begin
            in_valid  = ($urandom_range(0, 3) != 0);
            out_ready = ($urandom_range(0, 2) != 0);
            priv   = 1'($urandom);
            mmu_en = 1'($urandom);
            if ($urandom_range(0, 1) == 0)
                va = edges[$urandom_range(0, NB - 1)] + 32'($urandom_range(0, 4)) - 32'd2;
            else
                va = $urandom;
            rand_page();
            @(negedge clk);
        end
        in_valid = 0;
        out_ready = 1;
        repeat (3) @(negedge clk);
        // reset again mid-stream: R12
        in_valid = 1;
        rst = 1;
        in_rst_phase = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        in_valid = 0;
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule